// File: doc/BRIEF.md
# Make-Before-Break Group Commutation Sequencer

This block commands a row of solid-state selector switches so that an energised conduction group moves along a chain of coils one position at a time. There are sixteen selector enables, eight on the left side and eight on the right. A group is a fixed pairing of one left selector with the right selector at the same position, so the sequencer thinks in group indices but drives every selector line on its own.

Moving from one group to the next never opens the current path. The incoming pair is switched on while the outgoing pair is still on. All four selectors then stay on for a programmable number of clock cycles, and only then is the outgoing pair released. The block starts with every selector off and waits for an explicit start command that names the first group. It refuses to step past the last group and flags that refusal, because the chain does not wrap. All outputs come from registers, so each phase change reaches the selectors on a single clock edge.

The control is a three-state machine. ST_OFF has every selector open. ST_STEADY has one group closed. ST_OVERLAP has both the outgoing and the incoming group closed. The transitions are named as follows. "start accept" takes ST_OFF to ST_STEADY. "step accept" takes ST_STEADY to ST_OVERLAP. "overlap expiry" takes ST_OVERLAP back to ST_STEADY on the next group. "step refuse" leaves ST_STEADY where it is and raises the error pulse. Reset returns any state to ST_OFF.

Top module: `chain_commutator`

## Requirements
- R1: While reset is asserted, and after it is released, sel_o is all zero and busy_o, active_o, err_o and grp_o are zero, until a start is accepted.
- R2: Group index g (0..7, group number g+1) drives sel_o[g] (left selector) and sel_o[8+g] (right selector). In ST_STEADY exactly these two bits are high and grp_o equals g.
- R3: A start_i sampled in ST_OFF loads start_grp_i. From the following cycle, that group's two bits are high and active_o is 1. A start_i sampled in any other state has no effect.
- R4: A step_i sampled in ST_STEADY with grp_o below 7 is accepted. From the following cycle, sel_o has the bits of group g and of group g+1 high (four bits), busy_o is 1 and grp_o still shows g.
- R5: The overlap lasts N clock cycles, where N is overlap_i as sampled with the accepted step. A value of 0 is treated as 1. Later changes of overlap_i do not alter a running overlap.
- R6: When the overlap ends, one clock edge drops the outgoing pair, raises grp_o to g+1 and clears busy_o. No cycle during a step has neither pair on.
- R7: step_i while busy_o is 1 is ignored: the overlap is neither extended nor followed by a second advance.
- R8: step_i in ST_STEADY with grp_o equal to 7 is refused. sel_o and grp_o stay unchanged, busy_o stays 0, and err_o is 1 for exactly the following cycle.
- R9: step_i while in ST_OFF is ignored. No selector turns on and err_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Enables the first group; taken only while all selectors are off |
| start_grp_i | input | 3 | Group index loaded by an accepted start |
| step_i | input | 1 | Request to move the active group up by one position |
| overlap_i | input | 8 | Overlap length in clock cycles, 0 treated as 1 |
| sel_o | output | 16 | Selector enables: bits 7..0 left, bits 15..8 right |
| grp_o | output | 3 | Current steady group index |
| active_o | output | 1 | A group is enabled |
| busy_o | output | 1 | A make-before-break transition is in progress |
| err_o | output | 1 | One-cycle pulse when a step past the last group is refused |

## Verification
A wrong state register or a wrong group register shows at sel_o in the cycle right after the faulty edge. It appears as a left half that differs from the right half, as a bit count other than two while busy_o is low or four while it is high, or as a cycle with no bit shared with the previous cycle. A faulty overlap counter shows as an overlap window one cycle too short or too long. The group advance happens on the edge where busy_o falls, so a missing or double advance shows in grp_o at that same point.

// File: rtl/chain_commutator_pkg.sv
package chain_commutator_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_STEADY  = 2'd1,
        ST_OVERLAP = 2'd2
    } cc_state_e;

    typedef struct packed {
        logic start_ok;
        logic step_ok;
        logic step_err;
    } cc_req_t;

endpackage

// File: rtl/cc_req_guard.sv
module cc_req_guard
    import chain_commutator_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    localparam int IDX_W = $clog2(NUM_GROUPS)
) (
    input  cc_state_e        state_i,
    input  logic [IDX_W-1:0] grp_i,
    input  logic             start_i,
    input  logic             step_i,
    output cc_req_t          req_o
);
    localparam logic [IDX_W-1:0] LAST_GRP = IDX_W'(NUM_GROUPS - 1);

    logic in_steady;
    logic at_end;

    assign in_steady = (state_i == ST_STEADY);
    assign at_end    = (grp_i == LAST_GRP);

    always_comb begin
        req_o          = '0;
        req_o.start_ok = start_i && (state_i == ST_OFF);
        req_o.step_ok  = step_i && in_steady && !at_end;
        req_o.step_err = step_i && in_steady && at_end;
    end
endmodule

// File: rtl/cc_ovl_timer.sv
module cc_ovl_timer #(
    parameter int OVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [OVL_W-1:0] len_i,
    output logic             done_o
);
    logic [OVL_W-1:0] cnt_q;
    logic [OVL_W-1:0] len_eff;

    // a zero length still gives one overlap cycle
    assign len_eff = (len_i == '0) ? OVL_W'(1) : len_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_eff;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == OVL_W'(1));
endmodule

// File: rtl/cc_sel_encode.sv
module cc_sel_encode #(
    parameter int NUM_GROUPS = 8,
    localparam int IDX_W = $clog2(NUM_GROUPS),
    localparam int SEL_W = 2 * NUM_GROUPS
) (
    input  logic [IDX_W-1:0] cur_i,
    input  logic             cur_en_i,
    input  logic             nxt_en_i,
    output logic [SEL_W-1:0] sel_o
);
    logic [IDX_W-1:0] nxt;
    assign nxt = cur_i + 1'b1;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_pair
        logic hit;
        assign hit = (cur_en_i && (cur_i == IDX_W'(g))) ||
                     (nxt_en_i && (nxt   == IDX_W'(g)));
        assign sel_o[g]              = hit;
        assign sel_o[NUM_GROUPS + g] = hit;
    end
endmodule

// File: rtl/chain_commutator.sv
module chain_commutator
    import chain_commutator_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    parameter int OVL_W      = 8,
    localparam int IDX_W = $clog2(NUM_GROUPS),
    localparam int SEL_W = 2 * NUM_GROUPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] start_grp_i,
    input  logic             step_i,
    input  logic [OVL_W-1:0] overlap_i,
    output logic [SEL_W-1:0] sel_o,
    output logic [IDX_W-1:0] grp_o,
    output logic             active_o,
    output logic             busy_o,
    output logic             err_o
);
    cc_state_e        state_q, state_d;
    logic [IDX_W-1:0] grp_q, grp_d;
    cc_req_t          req;
    logic             ovl_done;
    logic [SEL_W-1:0] sel_d;

    cc_req_guard #(.NUM_GROUPS(NUM_GROUPS)) u_guard (
        .state_i (state_q),
        .grp_i   (grp_q),
        .start_i (start_i),
        .step_i  (step_i),
        .req_o   (req)
    );

    cc_ovl_timer #(.OVL_W(OVL_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (req.step_ok),
        .len_i  (overlap_i),
        .done_o (ovl_done)
    );

    // next-state and next-group decision
    always_comb begin
        state_d = state_q;
        grp_d   = grp_q;
        unique case (state_q)
            ST_OFF: begin
                if (req.start_ok) begin
                    state_d = ST_STEADY;
                    grp_d   = start_grp_i;
                end
            end
            ST_STEADY: begin
                if (req.step_ok) begin
                    state_d = ST_OVERLAP;
                end
            end
            ST_OVERLAP: begin
                if (ovl_done) begin
                    state_d = ST_STEADY;
                    grp_d   = grp_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_OFF;
                grp_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            grp_q   <= '0;
        end else begin
            state_q <= state_d;
            grp_q   <= grp_d;
        end
    end

    cc_sel_encode #(.NUM_GROUPS(NUM_GROUPS)) u_enc (
        .cur_i    (grp_d),
        .cur_en_i (state_d != ST_OFF),
        .nxt_en_i (state_d == ST_OVERLAP),
        .sel_o    (sel_d)
    );

    // output registers, loaded from the next state so a phase lands on one edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_o    <= '0;
            busy_o   <= 1'b0;
            active_o <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            sel_o    <= sel_d;
            busy_o   <= (state_d == ST_OVERLAP);
            active_o <= (state_d != ST_OFF);
            err_o    <= req.step_err;
        end
    end

    assign grp_o = grp_q;
endmodule

// File: rtl/chain_commutator_chk.sv
module chain_commutator_chk #(
    parameter int NUM_GROUPS = 8,
    localparam int IDX_W = $clog2(NUM_GROUPS),
    localparam int SEL_W = 2 * NUM_GROUPS
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] sel_o,
    input logic [IDX_W-1:0] grp_o,
    input logic             active_o,
    input logic             busy_o,
    input logic             err_o
);
    localparam logic [IDX_W-1:0] LAST_GRP = IDX_W'(NUM_GROUPS - 1);

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (sel_o == '0) && !busy_o);

    // R2
    pair_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o[NUM_GROUPS-1:0] == sel_o[SEL_W-1:NUM_GROUPS]);

    // R2
    steady_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !busy_o) |-> ($countones(sel_o) == 2) && sel_o[grp_o]);

    // R4
    overlap_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ($countones(sel_o) == 4) && sel_o[grp_o]);

    // R6
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(active_o) |-> active_o && ((sel_o & $past(sel_o)) != '0));

    // R6
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> grp_o == IDX_W'($past(grp_o) + 1'b1));

    // R8
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o && (grp_o == LAST_GRP) && $stable(sel_o));
endmodule

bind chain_commutator chain_commutator_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_o    (sel_o),
    .grp_o    (grp_o),
    .active_o (active_o),
    .busy_o   (busy_o),
    .err_o    (err_o)
);

// File: tb/chain_commutator_tb.sv
module chain_commutator_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  start_grp_i = '0;
    logic        step_i = 1'b0;
    logic [7:0]  overlap_i = '0;
    logic [15:0] sel_o;
    logic [2:0]  grp_o;
    logic        active_o, busy_o, err_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_commutator u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_grp_i(start_grp_i),
        .step_i(step_i), .overlap_i(overlap_i), .sel_o(sel_o), .grp_o(grp_o),
        .active_o(active_o), .busy_o(busy_o), .err_o(err_o)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic        start;
        logic [2:0]  sgrp;
        logic        step;
        logic [7:0]  ovl;
        logic [15:0] sel;
        logic        busy;
        logic [2:0]  grp;
        logic        err;
        logic        act;
    } vec_t;

    localparam int NV = 17;
    // rq, start, sgrp, step, ovl | sel, busy, grp, err, act
    localparam vec_t VECS [NV] = '{
        '{4'd9, 1'b0, 3'd0, 1'b1, 8'd0, 16'h0000, 1'b0, 3'd0, 1'b0, 1'b0}, // R9 step while off
        '{4'd3, 1'b1, 3'd2, 1'b0, 8'd0, 16'h0404, 1'b0, 3'd2, 1'b0, 1'b1}, // R3 start group 2
        '{4'd4, 1'b0, 3'd0, 1'b1, 8'd3, 16'h0C0C, 1'b1, 3'd2, 1'b0, 1'b1}, // R4 step, overlap 3
        '{4'd7, 1'b0, 3'd0, 1'b1, 8'd3, 16'h0C0C, 1'b1, 3'd2, 1'b0, 1'b1}, // R7 step while busy
        '{4'd5, 1'b0, 3'd0, 1'b0, 8'd0, 16'h0C0C, 1'b1, 3'd2, 1'b0, 1'b1}, // R5 third overlap cycle
        '{4'd6, 1'b0, 3'd0, 1'b0, 8'd0, 16'h0808, 1'b0, 3'd3, 1'b0, 1'b1}, // R6 release
        '{4'd5, 1'b0, 3'd0, 1'b1, 8'd0, 16'h1818, 1'b1, 3'd3, 1'b0, 1'b1}, // R5 zero as one
        '{4'd5, 1'b0, 3'd0, 1'b0, 8'd0, 16'h1010, 1'b0, 3'd4, 1'b0, 1'b1}, // R5 one cycle only
        '{4'd3, 1'b1, 3'd0, 1'b0, 8'd0, 16'h1010, 1'b0, 3'd4, 1'b0, 1'b1}, // R3 start ignored
        '{4'd4, 1'b0, 3'd0, 1'b1, 8'd1, 16'h3030, 1'b1, 3'd4, 1'b0, 1'b1}, // R4
        '{4'd2, 1'b0, 3'd0, 1'b0, 8'd0, 16'h2020, 1'b0, 3'd5, 1'b0, 1'b1}, // R2
        '{4'd4, 1'b0, 3'd0, 1'b1, 8'd1, 16'h6060, 1'b1, 3'd5, 1'b0, 1'b1}, // R4
        '{4'd2, 1'b0, 3'd0, 1'b0, 8'd0, 16'h4040, 1'b0, 3'd6, 1'b0, 1'b1}, // R2
        '{4'd4, 1'b0, 3'd0, 1'b1, 8'd1, 16'hC0C0, 1'b1, 3'd6, 1'b0, 1'b1}, // R4
        '{4'd6, 1'b0, 3'd0, 1'b0, 8'd0, 16'h8080, 1'b0, 3'd7, 1'b0, 1'b1}, // R6 last group
        '{4'd8, 1'b0, 3'd0, 1'b1, 8'd2, 16'h8080, 1'b0, 3'd7, 1'b1, 1'b1}, // R8 refused
        '{4'd8, 1'b0, 3'd0, 1'b0, 8'd0, 16'h8080, 1'b0, 3'd7, 1'b0, 1'b1}  // R8 pulse ends
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        // R1 reset state while held and after release
        chk("R1", "sel in reset", 32'(sel_o), 32'h0);
        chk("R1", "active in reset", 32'(active_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "sel after release", 32'(sel_o), 32'h0);
        chk("R1", "busy/err/grp", {busy_o, err_o, grp_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d v%0d", VECS[i].rq, i);
            start_i     = VECS[i].start;
            start_grp_i = VECS[i].sgrp;
            step_i      = VECS[i].step;
            overlap_i   = VECS[i].ovl;
            @(negedge clk);
            chk(tag, "sel",    32'(sel_o),    32'(VECS[i].sel));
            chk(tag, "busy",   32'(busy_o),   32'(VECS[i].busy));
            chk(tag, "grp",    32'(grp_o),    32'(VECS[i].grp));
            chk(tag, "err",    32'(err_o),    32'(VECS[i].err));
            chk(tag, "active", 32'(active_o), 32'(VECS[i].act));
        end
        start_i = 1'b0; step_i = 1'b0;

        // R1 reset from the last group
        rst_n = 1'b0;
        #1;
        chk("R1", "sel after async reset", 32'(sel_o), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 length 5, overlap_i changed mid-window has no effect
        start_i = 1'b1; start_grp_i = 3'd0;
        @(negedge clk);
        start_i = 1'b0;
        chk("R3", "start group 0", 32'(sel_o), 32'h0101);
        step_i = 1'b1; overlap_i = 8'd5;
        @(negedge clk);
        step_i = 1'b0; overlap_i = 8'd1;
        cnt = 0;
        while (busy_o && cnt < 20) begin
            cnt++;
            chk("R4", "four selectors on", 32'(sel_o), 32'h0303);
            @(negedge clk);
        end
        chk("R5", "overlap length latched", 32'(cnt), 32'd5);
        chk("R6", "sel after overlap", 32'(sel_o), 32'h0202);
        chk("R6", "grp after overlap", 32'(grp_o), 32'd1);

        // R1 reset in the middle of an overlap drops every selector
        step_i = 1'b1; overlap_i = 8'd4;
        @(negedge clk);
        step_i = 1'b0;
        chk("R4", "overlap before reset", 32'(sel_o), 32'h0606);
        rst_n = 1'b0;
        #1;
        chk("R1", "sel reset mid-overlap", 32'(sel_o), 32'h0);
        chk("R1", "busy reset mid-overlap", 32'(busy_o), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "still off after release", 32'(active_o), 32'h0);

        finish_run();
    end
endmodule